// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block sits between a simple register bus and the bit engine of a CAN controller. Its job is to stop mistakes in software from breaking the bus protocol. It keeps the controller's configuration registers: the clock-source select, two bit-timing bytes, an acceptance-control byte, eight acceptance codes and eight acceptance masks. Software can change these only while the controller is parked in initialization mode. Software enters that mode by setting a request bit, and the block confirms entry with an acknowledge bit. When the acknowledge bit is clear, writes to the locked registers are dropped without any effect.

The block also holds a module enable bit that accepts one write after reset. It holds receive and transmit error counters that take their values from test inputs and that software can only read. The selected controller clock enable drives a time-quantum prescaler. Whenever the controller is initializing or powered down, the transmit pin is held recessive.

Top module: `can_cfg_guard`

## Requirements
- R1: After reset, the mode register (address 0x00) reads 0x11: request bit 0 is set, power-down bit 1 is clear and acknowledge bit 4 is set. After reset, `canTxOut` is 1, the enable register (0x01) reads 0 and every locked register reads 0.
- R2: A write to a locked register takes effect only if `initAck` is 1 in the cycle of the write. When `initAck` is 0 the write is dropped. The locked registers are clock select 0x02 (bit 0 only), timing 0x03 and 0x04, acceptance control 0x05, codes 0x08–0x0F and masks 0x10–0x17.
- R3: `initAck` rises two clock edges after the edge that stores request bit 0 as 1. It falls two edges after the edge that stores that bit as 0.
- R4: `canTxOut` is 1 while the request bit, the acknowledge bit or power-down bit 1 of the mode register is set. Otherwise `canTxOut` follows `canTxIn`.
- R5: The enable register (0x01, bit 0) accepts the first write after reset in any mode. Every later write leaves it unchanged.
- R6: Addresses 0x06 and 0x07 read back `rxErrIn` and `txErrIn`, registered one cycle. Bus writes to these addresses have no effect.
- R7: Bits 5:0 of timing register 0x03 hold a value N. `tqTick` is a one-cycle pulse on every (N+1)-th active cycle of the selected clock enable.
- R8: Clock select bit 0 = 0 makes `oscCe` the prescaler's clock enable. Bit 0 = 1 makes `busCe` the clock enable.
- R9: An unmapped address reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address for both read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational from `addr`) |
| initAck | output | 1 | Initialization mode acknowledged |
| oscCe | input | 1 | Oscillator clock enable |
| busCe | input | 1 | Bus clock enable |
| rxErrIn | input | 8 | Receive error count (test input) |
| txErrIn | input | 8 | Transmit error count (test input) |
| canTxIn | input | 1 | Transmit bit from the bit engine |
| canTxOut | output | 1 | Transmit pin |
| tqTick | output | 1 | Time-quantum tick |

## Verification
A locked-register write can fall in the same cycle as a change of the acknowledge bit. The bench provokes this with writes on back-to-back edges right after the request bit is raised and again right after it is cleared. It then checks by readback that only the writes issued while the acknowledge bit was still high before the edge were kept. Online, a write to the clock select meets the prescaler's use of that same bit. The bench judges this case from the tick, which must keep following the oscillator enable.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  localparam int DW    = 8;
  localparam int AW    = 5;
  localparam int NFILT = 8;
  localparam int PSW   = 6;

  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_CLK  = AW'(2);
  localparam logic [AW-1:0] A_BT0  = AW'(3);
  localparam logic [AW-1:0] A_BT1  = AW'(4);
  localparam logic [AW-1:0] A_FCTL = AW'(5);
  localparam logic [AW-1:0] A_RXE  = AW'(6);
  localparam logic [AW-1:0] A_TXE  = AW'(7);
  localparam logic [AW-1:0] A_CODE = AW'(8);
  localparam logic [AW-1:0] A_MASK = AW'(16);

  typedef struct packed {
    logic          modeWr;
    logic          enWr;
    logic          protWr;
    logic [AW-1:0] wAddr;
    logic [DW-1:0] wData;
  } strobe_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import can_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output strobe_t       strb,
  output logic          initReq,
  output logic          pdReq,
  output logic          initAck,
  output logic          txForce
);
  logic reqSync;
  logic enUsed;
  logic protSel;

  // locked address set
  always_comb begin
    protSel = (addr == A_CLK) || (addr == A_BT0) || (addr == A_BT1) ||
              (addr == A_FCTL) ||
              ((addr >= A_CODE) && (addr < A_MASK + AW'(NFILT)));
  end

  always_comb begin
    strb.modeWr = wrEn && (addr == A_MODE);
    strb.enWr   = wrEn && (addr == A_EN) && !enUsed;
    strb.protWr = wrEn && protSel && initAck;
    strb.wAddr  = addr;
    strb.wData  = wrData;
  end

  // two-stage handshake: request -> sync -> acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initReq <= 1'b1;
      pdReq   <= 1'b0;
      reqSync <= 1'b1;
      initAck <= 1'b1;
      enUsed  <= 1'b0;
    end else begin
      if (strb.modeWr) begin
        initReq <= wrData[0];
        pdReq   <= wrData[1];
      end
      reqSync <= initReq;
      initAck <= reqSync;
      if (strb.enWr) enUsed <= 1'b1;
    end
  end

  assign txForce = initReq | initAck | pdReq;

  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(initReq) |=> ##1 initAck);
  assert_ack_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(initReq) |=> ##1 !initAck);
  assert_prot_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !initAck) |-> !strb.protWr);
  assert_en_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.enWr |=> !strb.enWr);
endmodule

// File: rtl/guard_regs.sv
module guard_regs
  import can_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strb,
  input  logic          initReq,
  input  logic          pdReq,
  input  logic          initAck,
  input  logic          oscCe,
  input  logic          busCe,
  input  logic [DW-1:0] rxErrIn,
  input  logic [DW-1:0] txErrIn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          tqTick
);
  logic          clkSrc;
  logic [DW-1:0] bt0, bt1, fctl;
  logic [DW-1:0] code [NFILT];
  logic [DW-1:0] mask [NFILT];
  logic          modEn;
  logic [DW-1:0] rxErr, txErr;
  logic [PSW-1:0] psCnt;
  logic [PSW-1:0] presc;
  logic          ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSrc <= 1'b0;
      bt0    <= '0;
      bt1    <= '0;
      fctl   <= '0;
      modEn  <= 1'b0;
      rxErr  <= '0;
      txErr  <= '0;
    end else begin
      if (strb.protWr) begin
        case (strb.wAddr)
          A_CLK:   clkSrc <= strb.wData[0];
          A_BT0:   bt0    <= strb.wData;
          A_BT1:   bt1    <= strb.wData;
          A_FCTL:  fctl   <= strb.wData;
          default: ;
        endcase
      end
      if (strb.enWr) modEn <= strb.wData[0];
      rxErr <= rxErrIn;
      txErr <= txErrIn;
    end
  end

  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code[i] <= '0;
        mask[i] <= '0;
      end else if (strb.protWr) begin
        if (strb.wAddr == A_CODE + AW'(i)) code[i] <= strb.wData;
        if (strb.wAddr == A_MASK + AW'(i)) mask[i] <= strb.wData;
      end
    end
  end

  // time-quantum prescaler on the selected clock enable
  assign presc = bt0[PSW-1:0];
  assign ce    = clkSrc ? busCe : oscCe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psCnt  <= '0;
      tqTick <= 1'b0;
    end else begin
      tqTick <= 1'b0;
      if (ce) begin
        if (psCnt >= presc) begin
          psCnt  <= '0;
          tqTick <= 1'b1;
        end else begin
          psCnt <= psCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_MODE: rdData = {3'b000, initAck, 2'b00, pdReq, initReq};
      A_EN:   rdData = {{(DW-1){1'b0}}, modEn};
      A_CLK:  rdData = {{(DW-1){1'b0}}, clkSrc};
      A_BT0:  rdData = bt0;
      A_BT1:  rdData = bt1;
      A_FCTL: rdData = fctl;
      A_RXE:  rdData = rxErr;
      A_TXE:  rdData = txErr;
      default: begin
        for (int i = 0; i < NFILT; i++) begin
          if (rdAddr == A_CODE + AW'(i)) rdData = code[i];
          if (rdAddr == A_MASK + AW'(i)) rdData = mask[i];
        end
      end
    endcase
  end

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tqTick && presc != '0) |=> !tqTick);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !initAck |=> $stable(bt0) && $stable(clkSrc));
endmodule

// File: rtl/can_cfg_guard.sv
module can_cfg_guard
  import can_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          initAck,
  input  logic          oscCe,
  input  logic          busCe,
  input  logic [DW-1:0] rxErrIn,
  input  logic [DW-1:0] txErrIn,
  input  logic          canTxIn,
  output logic          canTxOut,
  output logic          tqTick
);
  strobe_t strb;
  logic    initReq, pdReq, txForce;

  guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .initReq(initReq), .pdReq(pdReq), .initAck(initAck),
    .txForce(txForce)
  );

  guard_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .initReq(initReq), .pdReq(pdReq),
    .initAck(initAck), .oscCe(oscCe), .busCe(busCe), .rxErrIn(rxErrIn),
    .txErrIn(txErrIn), .rdAddr(addr), .rdData(rdData), .tqTick(tqTick)
  );

  assign canTxOut = txForce ? 1'b1 : canTxIn;

  assert_tx_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (initAck || pdReq) |-> canTxOut);
endmodule

// File: tb/sim_can_cfg_guard.sv
module sim_can_cfg_guard;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       initAck;
  logic       oscCe = 1'b0, busCe = 1'b0;
  logic [7:0] rxErrIn = 8'h21, txErrIn = 8'h42;
  logic       canTxIn = 1'b0;
  logic       canTxOut, tqTick;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  can_cfg_guard u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .initAck(initAck), .oscCe(oscCe), .busCe(busCe),
    .rxErrIn(rxErrIn), .txErrIn(txErrIn), .canTxIn(canTxIn),
    .canTxOut(canTxOut), .tqTick(tqTick)
  );

  // {addr, write data, expected readback}, written in init mode
  localparam logic [20:0] VEC [10] = '{
    {5'd2,  8'hFF, 8'h01}, {5'd3,  8'h45, 8'h45}, {5'd4,  8'h3C, 8'h3C},
    {5'd5,  8'h0F, 8'h0F}, {5'd8,  8'hA1, 8'hA1}, {5'd15, 8'hB2, 8'hB2},
    {5'd16, 8'hC3, 8'hC3}, {5'd23, 8'hD4, 8'hD4}, {5'd6,  8'hFF, 8'h21},
    {5'd7,  8'h00, 8'h42}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  // cycles between two ticks, 0 if none within the limit
  task automatic tickGap(output int gap);
    int n = 0;
    gap = 0;
    while (!tqTick && n < 40) begin @(posedge clk); #1; n++; end
    if (!tqTick) return;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!tqTick && n < 40);
    if (tqTick) gap = n;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int g;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(5'd0, v);  check("R1 mode", v, 8'h11);
    check("R1 tx", {7'b0, canTxOut}, 8'h01);
    rd(5'd1, v);  check("R1 enable", v, 8'h00);
    rd(5'd3, v);  check("R1 timing", v, 8'h00);
    rd(5'd17, v); check("R1 mask", v, 8'h00);

    // R2 R6 table walk in init mode
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], v);
      check("R2/R6 table", v, VEC[i][7:0]);
    end
    // R9 unmapped
    wr(5'd24, 8'hAA); rd(5'd24, v); check("R9 unmapped", v, 8'h00);

    // R7 prescaler N=2 on oscillator enable
    wr(5'd2, 8'h00); wr(5'd3, 8'h02);
    oscCe = 1'b1;
    tickGap(g); check("R7 period", 8'(g), 8'd3);
    @(posedge clk); #1; check("R7 pulse width", {7'b0, tqTick}, 8'h00);

    // R8 bus enable selected
    wr(5'd2, 8'h01);
    tickGap(g); check("R8 bus idle", 8'(g), 8'd0);
    busCe = 1'b1;
    tickGap(g); check("R8 bus ticks", 8'(g), 8'd3);
    busCe = 1'b0;
    wr(5'd2, 8'h00);

    // R5 write-once enable
    wr(5'd1, 8'h01); rd(5'd1, v); check("R5 first", v, 8'h01);
    wr(5'd1, 8'h00); rd(5'd1, v); check("R5 second", v, 8'h01);

    // R3 leave init mode
    canTxIn = 1'b0;
    wr(5'd0, 8'h00);
    check("R3 ack edge1", {7'b0, initAck}, 8'h01);
    @(posedge clk); #1; check("R3 ack edge2", {7'b0, initAck}, 8'h01);
    check("R4 tx during exit", {7'b0, canTxOut}, 8'h01);
    @(posedge clk); #1; check("R3 ack cleared", {7'b0, initAck}, 8'h00);

    // R4 online tx follows input, power-down forces recessive
    check("R4 tx low", {7'b0, canTxOut}, 8'h00);
    canTxIn = 1'b1; #1; check("R4 tx high", {7'b0, canTxOut}, 8'h01);
    canTxIn = 1'b0;
    wr(5'd0, 8'h02); check("R4 powerdown", {7'b0, canTxOut}, 8'h01);
    wr(5'd0, 8'h00); check("R4 wake", {7'b0, canTxOut}, 8'h00);

    // R2 online writes dropped; clock select locked (R8)
    wr(5'd3, 8'h77); rd(5'd3, v); check("R2 online drop", v, 8'h02);
    wr(5'd2, 8'h01); rd(5'd2, v); check("R2 clksel locked", v, 8'h00);
    tickGap(g); check("R8 still osc", 8'(g), 8'd3);
    // R6 write ignored, new input seen
    rxErrIn = 8'h9C;
    wr(5'd6, 8'h00); rd(5'd6, v); check("R6 rx ro", v, 8'h9C);
    wr(5'd1, 8'h00); rd(5'd1, v); check("R5 online", v, 8'h01);

    // R3 entry: ack rises two edges after request
    wr(5'd0, 8'h01);
    wr(5'd4, 8'h11);
    wr(5'd4, 8'h22);
    check("R3 ack rose", {7'b0, initAck}, 8'h01);
    rd(5'd4, v); check("R2 entry race", v, 8'h3C);
    wr(5'd4, 8'h5A); rd(5'd4, v); check("R2 entry open", v, 8'h5A);
    // exit race
    wr(5'd0, 8'h00);
    wr(5'd4, 8'h33);
    wr(5'd4, 8'h44);
    wr(5'd4, 8'h55);
    rd(5'd4, v); check("R2 exit race", v, 8'h44);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule